// File: doc/BRIEF.md
# Length-Decoded Serial Register Port

This block is a serial slave that fills three configuration registers without any address or steering bits in the stream. The host pulls an active-low enable, clocks data in most significant bit first, and releases the enable. The number of serial clocks counted while the enable was low decides which register, if any, takes the last bits shifted in. A write to the divide-ratio register also gives a one-cycle jam-load strobe, so that downstream counters restart together.

The serial pins are sampled by the system clock through a short synchronizer, and every action is taken on edges detected in the sampled domain. A 16-stage shift path with a half stage clocked on the falling serial edge drives a three-state output (data plus output enable), so a second port can be chained behind this one. A mid-length frame restores all three registers to their reset values. Serial pins are not a data stream with flow control: the host owns the serial clock and there is no back-pressure, so the port has no valid/ready handshake.

Top module: `sreg_port`

## Requirements
- R1: Serial data is taken on the rising edge of the serial clock, first bit the most significant, and the register receives the last bits of the frame in arrival order.
- R2: A frame of exactly 8 serial clocks writes the 8-bit configuration register with the last 8 bits.
- R3: A frame of exactly 16 clocks writes the 16-bit divide-N register and raises `jam_load` for exactly one system clock; no other frame length raises it.
- R4: A frame of 15 or 24 clocks writes the 15-bit divide-R register with the last 15 bits; in a 24-clock frame the first 9 bits have no effect.
- R5: A frame of 9 to 13 clocks restores configuration to 0x10 and both divide registers to 0.
- R6: Every other length, including 32 and lengths above 32, writes nothing; the bit counter saturates, so a long frame never aliases to a valid length (40 clocks does not act as 8).
- R7: Register outputs do not change while a frame is in progress; the update appears only after the enable returns high.
- R8: While enable is high, `ser_dout_oe` is 0 and serial clocks shift nothing into the port.
- R9: `ser_dout` is 0 at the start of a frame; the bit taken on rising edge k appears on `ser_dout` after falling edge k+15.
- R10: An enable edge seen while the serial clock is high is ignored: a falling one starts no frame and a rising one commits nothing. A later enable fall with the serial clock low starts a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out for chaining |
| ser_dout_oe | output | 1 | Drive enable for `ser_dout` (0 means high impedance) |
| cfg_q | output | 8 | Configuration register |
| ndiv_q | output | 16 | Divide-N register |
| rdiv_q | output | 15 | Divide-R register |
| jam_load | output | 1 | One-cycle strobe on a divide-N write |

## Verification
The bench sweeps every frame length from 1 to 40 against its own model. A decoder with an off-by-one boundary would corrupt registers at 7, 14, 17 or 25 clocks, and a counter that wraps would treat a 40-clock cascade frame as a configuration write. It also checks that registers stay frozen until the enable rises and that the chained output lags by exactly 16 clocks; a design without the half stage would be one bit early. Enable edges taken while the serial clock is high must be dropped, so a port that did not resynchronize would commit a stale frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [2:0] {
    WR_NONE,
    WR_CFG,
    WR_NDIV,
    WR_RDIV,
    WR_DEFAULTS
  } wr_kind_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic en_n_i,
  input  logic sdi_i,
  output logic sck_s,
  output logic en_n_s,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic en_rise,
  output logic en_fall
);
  // bit order in each stage: {sck, en_n, sdi}; idle is enable high, clock low
  localparam logic [2:0] IDLE = 3'b010;

  logic [STAGES-1:0][2:0] pipe;
  logic sck_d, en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
      sck_d <= 1'b0;
      en_d  <= 1'b1;
    end else begin
      pipe[0] <= {sck_i, en_n_i, sdi_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_d <= pipe[STAGES-1][2];
      en_d  <= pipe[STAGES-1][1];
    end
  end

  assign sck_s    = pipe[STAGES-1][2];
  assign en_n_s   = pipe[STAGES-1][1];
  assign sdi_s    = pipe[STAGES-1][0];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign en_rise  = en_n_s & ~en_d;
  assign en_fall  = ~en_n_s & en_d;
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter #(
  parameter int SH_W    = 16,
  parameter int MAX_LEN = 32,
  localparam int SAT    = MAX_LEN + 1,
  localparam int CW     = $clog2(SAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_s,
  input  logic            en_n_s,
  input  logic            sdi_s,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            en_rise,
  input  logic            en_fall,
  output logic            busy,
  output logic            done,
  output logic [CW-1:0]   len,
  output logic [SH_W-1:0] data,
  output logic            sdo,
  output logic            sdo_oe
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic            active;
  logic [CW-1:0]   cnt;
  logic [SH_W-1:0] sh;
  logic            half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      half_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (en_fall) begin
        if (!sck_s) begin
          active <= 1'b1;
          cnt    <= '0;
          sh     <= '0;
          half_q <= 1'b0;
        end
      end else if (en_rise) begin
        if (active && !sck_s) done <= 1'b1;
        active <= 1'b0;
      end else if (active) begin
        if (sck_rise) begin
          sh <= {sh[SH_W-2:0], sdi_s};
          if (cnt != SAT_V) cnt <= cnt + 1'b1;
        end
        if (sck_fall) half_q <= sh[SH_W-1];
      end
    end
  end

  assign busy   = active;
  assign len    = cnt;
  assign data   = sh;
  assign sdo    = half_q;
  assign sdo_oe = active;

  assert_idle_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n_s && $past(en_n_s)) |-> !sdo_oe);

  assert_count_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == SAT_V && sck_rise && !en_rise && !en_fall) |=> cnt == SAT_V);

  assert_dout_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sck_fall && !en_fall) |=> $stable(sdo));
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
  import sreg_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int NDIV_W   = 16,
  parameter int RDIV_W   = 15,
  parameter int RDIV_LONG = 24,
  parameter int RST_LO   = 9,
  parameter int RST_HI   = 13,
  parameter int SH_W     = 16,
  parameter int CW       = 6,
  parameter logic [CFG_W-1:0]  CFG_INIT  = 8'h10,
  parameter logic [NDIV_W-1:0] NDIV_INIT = '0,
  parameter logic [RDIV_W-1:0] RDIV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              done,
  input  logic [CW-1:0]     len,
  input  logic [SH_W-1:0]   data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [NDIV_W-1:0] ndiv_q,
  output logic [RDIV_W-1:0] rdiv_q,
  output logic              jam_load
);
  localparam logic [CW-1:0] L_CFG = CW'(CFG_W);
  localparam logic [CW-1:0] L_N   = CW'(NDIV_W);
  localparam logic [CW-1:0] L_RS  = CW'(RDIV_W);
  localparam logic [CW-1:0] L_RL  = CW'(RDIV_LONG);
  localparam logic [CW-1:0] L_LO  = CW'(RST_LO);
  localparam logic [CW-1:0] L_HI  = CW'(RST_HI);

  wr_kind_e kind;

  always_comb begin
    kind = WR_NONE;
    if (len == L_CFG)                    kind = WR_CFG;
    else if (len == L_N)                 kind = WR_NDIV;
    else if (len == L_RS || len == L_RL) kind = WR_RDIV;
    else if (len >= L_LO && len <= L_HI) kind = WR_DEFAULTS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_INIT;
      ndiv_q   <= NDIV_INIT;
      rdiv_q   <= RDIV_INIT;
      jam_load <= 1'b0;
    end else begin
      jam_load <= 1'b0;
      if (done) begin
        unique case (kind)
          WR_CFG:  cfg_q <= data[CFG_W-1:0];
          WR_NDIV: begin
            ndiv_q   <= data[NDIV_W-1:0];
            jam_load <= 1'b1;
          end
          WR_RDIV: rdiv_q <= data[RDIV_W-1:0];
          WR_DEFAULTS: begin
            cfg_q  <= CFG_INIT;
            ndiv_q <= NDIV_INIT;
            rdiv_q <= RDIV_INIT;
          end
          default: ;
        endcase
      end
    end
  end

  assert_regs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable({cfg_q, ndiv_q, rdiv_q}));

  assert_jam_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jam_load |=> !jam_load);

  assert_jam_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jam_load |-> (!busy && $past(done)));
endmodule

// File: rtl/sreg_port.sv
module sreg_port #(
  parameter int CFG_W       = 8,
  parameter int NDIV_W      = 16,
  parameter int RDIV_W      = 15,
  parameter int RDIV_LONG   = 24,
  parameter int RST_LO      = 9,
  parameter int RST_HI      = 13,
  parameter int MAX_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0]  CFG_INIT  = 8'h10,
  parameter logic [NDIV_W-1:0] NDIV_INIT = '0,
  parameter logic [RDIV_W-1:0] RDIV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_dout_oe,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [NDIV_W-1:0] ndiv_q,
  output logic [RDIV_W-1:0] rdiv_q,
  output logic              jam_load
);
  localparam int SH_A = (CFG_W > NDIV_W) ? CFG_W : NDIV_W;
  localparam int SH_W = (SH_A > RDIV_W) ? SH_A : RDIV_W;
  localparam int CW   = $clog2(MAX_LEN + 2);

  logic sck_s, en_n_s, sdi_s, sck_rise, sck_fall, en_rise, en_fall;
  logic busy, done;
  logic [CW-1:0]   len;
  logic [SH_W-1:0] data;

  sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sck_i(ser_clk), .en_n_i(ser_en_n), .sdi_i(ser_din),
    .sck_s(sck_s), .en_n_s(en_n_s), .sdi_s(sdi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .en_rise(en_rise), .en_fall(en_fall)
  );

  sreg_shifter #(.SH_W(SH_W), .MAX_LEN(MAX_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_s(sck_s), .en_n_s(en_n_s), .sdi_s(sdi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .en_rise(en_rise), .en_fall(en_fall),
    .busy(busy), .done(done), .len(len), .data(data),
    .sdo(ser_dout), .sdo_oe(ser_dout_oe)
  );

  sreg_regfile #(
    .CFG_W(CFG_W), .NDIV_W(NDIV_W), .RDIV_W(RDIV_W), .RDIV_LONG(RDIV_LONG),
    .RST_LO(RST_LO), .RST_HI(RST_HI), .SH_W(SH_W), .CW(CW),
    .CFG_INIT(CFG_INIT), .NDIV_INIT(NDIV_INIT), .RDIV_INIT(RDIV_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .done(done), .len(len), .data(data),
    .cfg_q(cfg_q), .ndiv_q(ndiv_q), .rdiv_q(rdiv_q), .jam_load(jam_load)
  );
endmodule

// File: tb/sreg_port_tb.sv
module sreg_port_tb_top;
  localparam int HALF  = 6;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_dout_oe, jam_load;
  logic [7:0]  cfg_q;
  logic [15:0] ndiv_q;
  logic [14:0] rdiv_q;

  always #2.5 clk = ~clk;

  sreg_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
    .cfg_q(cfg_q), .ndiv_q(ndiv_q), .rdiv_q(rdiv_q), .jam_load(jam_load)
  );

  int nchk = 0, nerr = 0, jam_seen = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0]  e_cfg = 8'h10;
  logic [15:0] e_n = '0;
  logic [14:0] e_r = '0;
  logic got [1:64];

  typedef struct packed { int len; logic [63:0] bits; } vec_t;
  localparam vec_t VECS [10] = '{
    '{8,  64'h00000000000000A5},
    '{16, 64'h000000000000C3E1},
    '{15, 64'h0000000000005B2D},
    '{24, 64'h0000000000FFA817},
    '{11, 64'h00000000000007FF},
    '{16, 64'h0000000000000028},
    '{24, 64'h0000000000000005},
    '{7,  64'h000000000000007F},
    '{32, 64'h00000000DEADBEEF},
    '{8,  64'h000000000000003C}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (jam_load) jam_seen <= jam_seen + 1;
    if (cyc > LIMIT && !finished) begin
      finished = 1'b1;
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    chk(cfg_q == e_cfg, {req, " cfg"}, 64'(cfg_q), 64'(e_cfg));
    chk(ndiv_q == e_n, {req, " ndiv"}, 64'(ndiv_q), 64'(e_n));
    chk(rdiv_q == e_r, {req, " rdiv"}, 64'(rdiv_q), 64'(e_r));
  endtask

  task automatic one_bit(input logic b, input int j);
    ser_din = b;
    wait_n(HALF);
    ser_clk = 1'b1;
    wait_n(HALF);
    ser_clk = 1'b0;
    wait_n(HALF);
    got[j] = ser_dout;
  endtask

  task automatic model(input int n, input logic [63:0] b);
    if (n == 8) e_cfg = b[7:0];                        // R2
    else if (n == 16) e_n = b[15:0];                   // R3
    else if (n == 15 || n == 24) e_r = b[14:0];        // R4
    else if (n >= 9 && n <= 13) begin                  // R5
      e_cfg = 8'h10; e_n = '0; e_r = '0;
    end
    // R6: any other length leaves the model unchanged
  endtask

  task automatic frame(input int n, input logic [63:0] b);
    int jam0;
    jam0 = jam_seen;
    ser_en_n = 1'b0;
    wait_n(HALF);
    chk(ser_dout_oe == 1'b1, "R8 oe in frame", 64'(ser_dout_oe), 64'd1);
    for (int j = 1; j <= n; j++) one_bit(b[n-j], j);
    check_regs("R7 frozen before enable rise");
    for (int j = 1; j <= n; j++) begin
      logic e;
      e = (j >= 16) ? b[n-(j-15)] : 1'b0;
      chk(got[j] === e, $sformatf("R9 dout bit %0d of len %0d", j, n), 64'(got[j]), 64'(e));
    end
    ser_en_n = 1'b1;
    wait_n(3 * HALF);
    model(n, b);
    check_regs($sformatf("R1 R2 R4 R5 R6 after len %0d", n));
    chk(ser_dout_oe == 1'b0, "R8 oe idle", 64'(ser_dout_oe), 64'd0);
    chk((jam_seen - jam0) == ((n == 16) ? 1 : 0), $sformatf("R3 jam count len %0d", n),
        64'(jam_seen - jam0), 64'((n == 16) ? 1 : 0));
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    check_regs("R5 reset values");
    chk(ser_dout_oe == 1'b0, "R8 reset oe", 64'(ser_dout_oe), 64'd0);
    chk(jam_load == 1'b0, "R3 reset jam", 64'(jam_load), 64'd0);

    for (int v = 0; v < 10; v++) frame(VECS[v].len, VECS[v].bits);

    for (int n = 1; n <= 40; n++)
      frame(n, 64'hA5C3_96E1_5A3C_6B1D ^ (64'(n) * 64'h0000_0000_9E37_79B9));

    frame(8, 64'h5A);

    // R8: serial clocks with enable high shift nothing
    for (int j = 1; j <= 8; j++) one_bit(1'b1, j);
    chk(ser_dout_oe == 1'b0, "R8 no drive with enable high", 64'(ser_dout_oe), 64'd0);
    ser_en_n = 1'b0; wait_n(HALF); ser_en_n = 1'b1; wait_n(3 * HALF);
    check_regs("R8 zero-length after idle clocks");

    // R10: enable falls while clock high, frame ignored
    ser_clk = 1'b1; wait_n(HALF);
    ser_en_n = 1'b0; wait_n(HALF);
    ser_clk = 1'b0; wait_n(HALF);
    chk(ser_dout_oe == 1'b0, "R10 no frame after fall with clock high", 64'(ser_dout_oe), 64'd0);
    for (int j = 1; j <= 8; j++) one_bit(1'b1, j);
    ser_en_n = 1'b1; wait_n(3 * HALF);
    check_regs("R10 ignored falling enable");

    // R10: enable rises while clock high, no commit
    ser_en_n = 1'b0; wait_n(HALF);
    for (int j = 1; j <= 8; j++) one_bit(1'b0, j);
    ser_clk = 1'b1; wait_n(HALF);
    ser_en_n = 1'b1; wait_n(HALF);
    ser_clk = 1'b0; wait_n(3 * HALF);
    check_regs("R10 ignored rising enable");

    // R10: resynchronized, a normal frame works again
    frame(8, 64'hC7);
    chk(cfg_q == 8'hC7, "R10 resync write", 64'(cfg_q), 64'hC7);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule